// File: doc/BRIEF.md
# Synchronous burst pseudo-SRAM controller

This block sits on the host side of a 16-bit synchronous burst pseudo-SRAM and turns single user requests into fixed-shape bursts of four beats. One request carries a start address, a direction and two byte-enable bits. The controller drives the memory's address-valid, chip-select, write-enable, output-enable and byte-enable strobes. It counts latency clocks from the edge at which the memory samples the address. For writes it pulls beats from a user write stream one cycle before it drives each one. For reads it returns beats on a read stream with a one-cycle valid strobe.

Cycle numbering below counts from the cycle in which address-valid is low (cycle 0). The memory takes the address at the end of cycle 0, and the latency is LATENCY = 5 clocks. On reads the memory's WAIT line must be high by the end of cycle LATENCY-2. If it is not, the controller aborts the burst and raises a sticky error flag.

The controller also enforces a minimum idle time between bursts, derived from a gap in picoseconds and the clock period. It cuts any burst that would keep chip-select low longer than a wall-clock limit, also derived from the clock period. WAIT is looked at only while a read burst holds chip-select low, so its undriven state outside bursts has no effect.

Top module: `psram_burst_ctrl`

## Requirements
- R1: After reset, mem_cs_n, mem_adv_n, mem_we_n and mem_oe_n are 1, mem_be_n is 2'b11, and mem_dq_oe, ack, err, rd_valid and wr_rdy are 0.
- R2: A request is taken only when no burst or gap is in progress. Address-valid is then low for exactly one cycle (cycle 0), with chip-select low and mem_addr equal to req_addr.
- R3: In a write burst, mem_we_n is low and mem_oe_n is high while chip-select is low. wr_rdy is high in cycles LATENCY-2 to LATENCY+BURST_LEN-3. The word presented on wr_data while wr_rdy is high is driven on mem_dq_o with mem_dq_oe high one cycle later, in request order.
- R4: In a read burst, mem_we_n stays high, mem_oe_n is low from cycle 1 until chip-select rises, and mem_dq_oe stays 0. mem_dq_i is captured at the end of cycles LATENCY-1 to LATENCY+BURST_LEN-2. Each captured word appears on rd_data with rd_valid high in the following cycle, in address order.
- R5: In a read burst, if mem_wait is 0 at the end of cycle LATENCY-2, err is set. Chip-select is then high from cycle LATENCY-1 (it was low for LATENCY-1 cycles), ack pulses, and rd_valid never rises for that burst.
- R6: Write bursts complete normally while mem_wait is held low, because WAIT is not checked on writes.
- R7: A burst that is not cut holds chip-select low for exactly LATENCY+BURST_LEN-1 cycles. ack is a one-cycle pulse in the first cycle with chip-select high again.
- R8: Between the rise of chip-select and the next address-valid, chip-select stays high for at least GAP_CYC+1 cycles, where GAP_CYC = max(1, ceil(GAP_PS / CLK_PERIOD_PS)). With a request waiting, the gap is exactly that long.
- R9: Chip-select is never low for more than MAX_CYC = floor(MAX_BURST_PS / CLK_PERIOD_PS) consecutive cycles. A burst cut at that limit sets err and pulses ack, and it requests no write beat in its final low cycle.
- R10: mem_be_n equals the inverse of req_be (bit 1 upper byte, bit 0 lower byte) for every cycle chip-select is low. Only enabled bytes are written in the memory.
- R11: Once set, err stays 1 until reset, and later bursts still run normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller and memory clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Burst request |
| req_we | input | 1 | 1 = write burst, 0 = read burst |
| req_addr | input | ADDR_W | Burst start word address |
| req_be | input | DATA_W/8 | Byte enables, active high, bit 1 = upper byte |
| ack | output | 1 | One-cycle pulse when the burst ends |
| err | output | 1 | Sticky error: WAIT missing or burst cut |
| wr_data | input | DATA_W | Write beat, taken while wr_rdy is high |
| wr_rdy | output | 1 | Write beat request |
| rd_data | output | DATA_W | Read beat |
| rd_valid | output | 1 | Read beat strobe |
| mem_clk | output | 1 | Memory clock |
| mem_adv_n | output | 1 | Address valid, active low |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_be_n | output | DATA_W/8 | Byte enables to memory, active low |
| mem_addr | output | ADDR_W | Address to memory |
| mem_dq_o | output | DATA_W | Data toward memory |
| mem_dq_oe | output | 1 | Drive enable for the data bus |
| mem_dq_i | input | DATA_W | Data from memory |
| mem_wait | input | 1 | Memory WAIT, high = data available |

## Verification
The main instance is built with CLK_PERIOD_PS = 4000. That gives GAP_CYC = 2, so the exact three-cycle spacing between back-to-back bursts becomes visible. The wall-clock limit stays far above the natural eight-cycle burst. A second instance uses the same clock but MAX_BURST_PS = 28000, which gives MAX_CYC = 7, one cycle below the natural burst length, so the truncation path and its dropped write beat can be reached. A behavioural memory on the main instance stores bytes under the byte enables and can hold WAIT low, which makes the abort and the sticky error reachable.

// File: rtl/psram_pkg.sv
package psram_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ADDR  = 2'd1,
    ST_BURST = 2'd2,
    ST_GAP   = 2'd3
  } psram_state_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/psram_rst_sync.sv
module psram_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_sync = sync_q;

endmodule

// File: rtl/psram_span_timer.sv
module psram_span_timer #(
  parameter int MAX_CYC = 625
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_low,
  output logic limit_hit
);

  localparam int CW = $clog2(MAX_CYC + 1);
  localparam logic [CW-1:0] LAST_C = CW'(MAX_CYC - 1);

  logic [CW-1:0] span_q;
  logic [CW-1:0] span_d;
  logic          span_en;

  // Count low cycles of chip-select; clear once it is high again.
  always_comb begin
    span_en = cs_low || (span_q != '0);
    span_d  = cs_low ? span_q + CW'(1) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      span_q <= '0;
    end else if (span_en) begin
      span_q <= span_d;
    end
  end

  assign limit_hit = cs_low && (span_q == LAST_C);

endmodule

// File: rtl/psram_ctrl_fsm.sv
module psram_ctrl_fsm
  import psram_pkg::*;
#(
  parameter int ADDR_W    = 22,
  parameter int BE_W      = 2,
  parameter int LATENCY   = 5,
  parameter int BURST_LEN = 4,
  parameter int GAP_CYC   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BE_W-1:0]   req_be,
  input  logic              limit_hit,
  input  logic              wait_i,
  output logic              ack,
  output logic              err,
  output logic              wr_rdy,
  output logic              rd_cap,
  output logic              adv_n,
  output logic              cs_n,
  output logic              we_n,
  output logic              oe_n,
  output logic [BE_W-1:0]   be_n,
  output logic [ADDR_W-1:0] addr
);

  localparam int LCW = $clog2(LATENCY + BURST_LEN + 1);
  localparam int GCW = $clog2(GAP_CYC + 1);
  localparam logic [LCW-1:0] WR_FIRST = LCW'(LATENCY - 2);
  localparam logic [LCW-1:0] WR_LAST  = LCW'(LATENCY + BURST_LEN - 3);
  localparam logic [LCW-1:0] RD_FIRST = LCW'(LATENCY - 1);
  localparam logic [LCW-1:0] RD_LAST  = LCW'(LATENCY + BURST_LEN - 2);
  localparam logic [LCW-1:0] WAIT_CHK = LCW'(LATENCY - 2);
  localparam logic [GCW-1:0] GAP_LAST = GCW'(GAP_CYC - 1);

  psram_state_e      st_q, st_d;
  logic [LCW-1:0]    lcnt_q, lcnt_d;
  logic [GCW-1:0]    gcnt_q, gcnt_d;
  logic              dir_q, dir_d;
  logic              adv_q, adv_d, cs_q, cs_d, we_q, we_d, oe_q, oe_d;
  logic [BE_W-1:0]   be_q, be_d;
  logic [ADDR_W-1:0] addr_q;
  logic              ack_q, ack_d, err_q, err_d;
  logic              accept;
  logic              in_burst, wr_win, rd_win, wait_bad, nat_end, stop, err_set;

  // Beat windows and end conditions, counted from the address cycle.
  always_comb begin
    in_burst = (st_q == ST_BURST);
    wr_win   = in_burst && dir_q && (lcnt_q >= WR_FIRST) && (lcnt_q <= WR_LAST);
    rd_win   = in_burst && !dir_q && (lcnt_q >= RD_FIRST) && (lcnt_q <= RD_LAST);
    wait_bad = in_burst && !dir_q && (lcnt_q == WAIT_CHK) && !wait_i;
    nat_end  = in_burst && (lcnt_q == RD_LAST);
    stop     = in_burst && (nat_end || wait_bad || limit_hit);
    err_set  = stop && (wait_bad || (limit_hit && !nat_end));
  end

  assign wr_rdy = wr_win && !limit_hit;
  assign rd_cap = rd_win;

  always_comb begin
    st_d   = st_q;
    lcnt_d = lcnt_q;
    gcnt_d = gcnt_q;
    dir_d  = dir_q;
    adv_d  = adv_q;
    cs_d   = cs_q;
    we_d   = we_q;
    oe_d   = oe_q;
    be_d   = be_q;
    ack_d  = 1'b0;
    err_d  = err_q || err_set;
    accept = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (req) begin
          accept = 1'b1;
          st_d   = ST_ADDR;
          adv_d  = 1'b0;
          cs_d   = 1'b0;
          we_d   = !req_we;
          dir_d  = req_we;
          be_d   = ~req_be;
        end
      end
      ST_ADDR: begin
        st_d   = ST_BURST;
        adv_d  = 1'b1;
        lcnt_d = LCW'(1);
        oe_d   = dir_q;
      end
      ST_BURST: begin
        if (stop) begin
          st_d   = ST_GAP;
          cs_d   = 1'b1;
          we_d   = 1'b1;
          oe_d   = 1'b1;
          be_d   = '1;
          ack_d  = 1'b1;
          gcnt_d = '0;
        end else begin
          lcnt_d = lcnt_q + LCW'(1);
        end
      end
      ST_GAP: begin
        if (gcnt_q == GAP_LAST) begin
          st_d = ST_IDLE;
        end else begin
          gcnt_d = gcnt_q + GCW'(1);
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      lcnt_q <= '0;
      gcnt_q <= '0;
      dir_q  <= 1'b0;
      adv_q  <= 1'b1;
      cs_q   <= 1'b1;
      we_q   <= 1'b1;
      oe_q   <= 1'b1;
      be_q   <= '1;
      ack_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      lcnt_q <= lcnt_d;
      gcnt_q <= gcnt_d;
      dir_q  <= dir_d;
      adv_q  <= adv_d;
      cs_q   <= cs_d;
      we_q   <= we_d;
      oe_q   <= oe_d;
      be_q   <= be_d;
      ack_q  <= ack_d;
      err_q  <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (accept) begin
      addr_q <= req_addr;
    end
  end

  assign ack   = ack_q;
  assign err   = err_q;
  assign adv_n = adv_q;
  assign cs_n  = cs_q;
  assign we_n  = we_q;
  assign oe_n  = oe_q;
  assign be_n  = be_q;
  assign addr  = addr_q;

endmodule

// File: rtl/psram_dq_path.sv
module psram_dq_path #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_take,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_cap,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  logic [DATA_W-1:0] dq_o_q, rd_data_q;
  logic              dq_oe_q, rd_valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_oe_q    <= 1'b0;
      rd_valid_q <= 1'b0;
    end else begin
      dq_oe_q    <= wr_take;
      rd_valid_q <= rd_cap;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_o_q <= '0;
    end else if (wr_take) begin
      dq_o_q <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data_q <= '0;
    end else if (rd_cap) begin
      rd_data_q <= dq_i;
    end
  end

  assign dq_o     = dq_o_q;
  assign dq_oe    = dq_oe_q;
  assign rd_data  = rd_data_q;
  assign rd_valid = rd_valid_q;

endmodule

// File: rtl/psram_burst_ctrl.sv
module psram_burst_ctrl
  import psram_pkg::*;
#(
  parameter int ADDR_W        = 22,
  parameter int DATA_W        = 16,
  parameter int LATENCY       = 5,
  parameter int BURST_LEN     = 4,
  parameter int CLK_PERIOD_PS = 10000,
  parameter int GAP_PS        = 7000,
  parameter int MAX_BURST_PS  = 2500000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req,
  input  logic                req_we,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W/8-1:0] req_be,
  output logic                ack,
  output logic                err,
  input  logic [DATA_W-1:0]   wr_data,
  output logic                wr_rdy,
  output logic [DATA_W-1:0]   rd_data,
  output logic                rd_valid,
  output logic                mem_clk,
  output logic                mem_adv_n,
  output logic                mem_cs_n,
  output logic                mem_we_n,
  output logic                mem_oe_n,
  output logic [DATA_W/8-1:0] mem_be_n,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]   mem_dq_o,
  output logic                mem_dq_oe,
  input  logic [DATA_W-1:0]   mem_dq_i,
  input  logic                mem_wait
);

  localparam int BE_W     = DATA_W / 8;
  localparam int GAP_RAW  = ceil_div(GAP_PS, CLK_PERIOD_PS);
  localparam int GAP_CYC  = (GAP_RAW < 1) ? 1 : GAP_RAW;
  localparam int MAX_CYC  = MAX_BURST_PS / CLK_PERIOD_PS;

  logic rst_n_int;
  logic limit_hit;
  logic rd_cap;

  assign mem_clk = clk;

  psram_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  psram_span_timer #(.MAX_CYC(MAX_CYC)) u_span (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .cs_low    (!mem_cs_n),
    .limit_hit (limit_hit)
  );

  psram_ctrl_fsm #(
    .ADDR_W    (ADDR_W),
    .BE_W      (BE_W),
    .LATENCY   (LATENCY),
    .BURST_LEN (BURST_LEN),
    .GAP_CYC   (GAP_CYC)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .req       (req),
    .req_we    (req_we),
    .req_addr  (req_addr),
    .req_be    (req_be),
    .limit_hit (limit_hit),
    .wait_i    (mem_wait),
    .ack       (ack),
    .err       (err),
    .wr_rdy    (wr_rdy),
    .rd_cap    (rd_cap),
    .adv_n     (mem_adv_n),
    .cs_n      (mem_cs_n),
    .we_n      (mem_we_n),
    .oe_n      (mem_oe_n),
    .be_n      (mem_be_n),
    .addr      (mem_addr)
  );

  psram_dq_path #(.DATA_W(DATA_W)) u_dq (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .wr_take  (wr_rdy),
    .wr_data  (wr_data),
    .rd_cap   (rd_cap),
    .dq_i     (mem_dq_i),
    .dq_o     (mem_dq_o),
    .dq_oe    (mem_dq_oe),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );

endmodule

// File: rtl/psram_burst_chk.sv
module psram_burst_chk #(
  parameter int GAP_CYC = 1,
  parameter int MAX_CYC = 625
) (
  input logic clk,
  input logic rst_n,
  input logic adv_n,
  input logic cs_n,
  input logic we_n,
  input logic oe_n,
  input logic dq_oe,
  input logic ack,
  input logic err
);

  localparam int HW = $clog2(GAP_CYC + 3);
  localparam int LW = $clog2(MAX_CYC + 3);
  localparam logic [HW-1:0] HI_MIN = HW'(GAP_CYC + 1);
  localparam logic [LW-1:0] LO_MAX = LW'(MAX_CYC);

  logic [HW-1:0] hi_cnt;
  logic [LW-1:0] lo_cnt;
  logic          seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= '0;
      lo_cnt <= '0;
      seen   <= 1'b0;
    end else begin
      if (cs_n) begin
        if (hi_cnt != HI_MIN) hi_cnt <= hi_cnt + HW'(1);
        lo_cnt <= '0;
      end else begin
        hi_cnt <= '0;
        if (lo_cnt != LO_MAX) lo_cnt <= lo_cnt + LW'(1);
      end
      if (!adv_n) seen <= 1'b1;
    end
  end

  AST_ADV_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_n |=> adv_n) else $error("adv low for more than one cycle"); // R2
  AST_ADV_WITH_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_n |-> !cs_n) else $error("adv low without chip select"); // R2
  AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> (we_n || oe_n)) else $error("we and oe both low"); // R4
  AST_DQ_OE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (!we_n && !cs_n)) else $error("bus driven outside write"); // R3
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack) else $error("ack longer than one cycle"); // R7
  AST_ACK_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> cs_n) else $error("ack while chip select low"); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err) else $error("err cleared"); // R11
  AST_GAP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_n && seen) |-> (hi_cnt >= HI_MIN)) else $error("gap too short"); // R8
  AST_SPAN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> (lo_cnt < LO_MAX)) else $error("burst too long"); // R9

endmodule

bind psram_burst_ctrl psram_burst_chk #(.GAP_CYC(GAP_CYC), .MAX_CYC(MAX_CYC)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .adv_n (mem_adv_n),
  .cs_n  (mem_cs_n),
  .we_n  (mem_we_n),
  .oe_n  (mem_oe_n),
  .dq_oe (mem_dq_oe),
  .ack   (ack),
  .err   (err)
);

// File: tb/psram_burst_ctrl_tb.sv
module psram_burst_ctrl_tb;

  localparam int CLK_PERIOD = 4;
  localparam int PERIOD_PS  = 4000;
  localparam int LAT        = 5;
  localparam int BL         = 4;
  localparam int GAP_CYC    = 2;
  localparam int CUT_CYC    = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic        req = 1'b0, req_we = 1'b0;
  logic [21:0] req_addr = '0;
  logic [1:0]  req_be = 2'b11;
  logic [15:0] wr_data = '0;
  logic        ack, err, wr_rdy, rd_valid, mem_clk;
  logic [15:0] rd_data, mem_dq_o;
  logic        mem_adv_n, mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [1:0]  mem_be_n;
  logic [21:0] mem_addr;
  logic [15:0] mem_dq_i;
  logic        mem_wait;

  psram_burst_ctrl #(.CLK_PERIOD_PS(PERIOD_PS)) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr),
    .req_be(req_be), .ack(ack), .err(err), .wr_data(wr_data), .wr_rdy(wr_rdy),
    .rd_data(rd_data), .rd_valid(rd_valid), .mem_clk(mem_clk), .mem_adv_n(mem_adv_n),
    .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n),
    .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
    .mem_dq_i(mem_dq_i), .mem_wait(mem_wait)
  );

  logic        c_req = 1'b0;
  logic        c_ack, c_err, c_wr_rdy, c_rd_valid, c_mem_clk;
  logic [15:0] c_rd_data, c_dq_o;
  logic        c_adv_n, c_cs_n, c_we_n, c_oe_n, c_dq_oe;
  logic [1:0]  c_be_n;
  logic [21:0] c_addr;

  psram_burst_ctrl #(.CLK_PERIOD_PS(PERIOD_PS), .MAX_BURST_PS(28000)) u_cut (
    .clk(clk), .rst_n(rst_n), .req(c_req), .req_we(1'b1), .req_addr(22'h10),
    .req_be(2'b11), .ack(c_ack), .err(c_err), .wr_data(16'h5a5a), .wr_rdy(c_wr_rdy),
    .rd_data(c_rd_data), .rd_valid(c_rd_valid), .mem_clk(c_mem_clk), .mem_adv_n(c_adv_n),
    .mem_cs_n(c_cs_n), .mem_we_n(c_we_n), .mem_oe_n(c_oe_n), .mem_be_n(c_be_n),
    .mem_addr(c_addr), .mem_dq_o(c_dq_o), .mem_dq_oe(c_dq_oe),
    .mem_dq_i(16'h0), .mem_wait(1'b0)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // Behavioural memory: 16 words, byte enables, WAIT high from cycle LAT-2 on reads.
  logic [15:0] mem [16];
  logic        m_act = 1'b0, m_we = 1'b0, wait_bad = 1'b0;
  logic [3:0]  m_a = '0;
  int          m_k = 0;
  initial begin
    mem_dq_i = '0;
    mem_wait = 1'b0;
  end

  always @(posedge clk) begin
    int kn;
    if (mem_cs_n) begin
      m_act    <= 1'b0;
      mem_wait <= 1'b0;
    end else if (!mem_adv_n) begin
      m_act <= 1'b1;
      m_k   <= 1;
      m_we  <= !mem_we_n;
      m_a   <= mem_addr[3:0];
    end else if (m_act) begin
      kn = m_k + 1;
      m_k <= kn;
      if (m_we && kn >= LAT && kn <= LAT + BL - 1) begin
        if (!mem_be_n[0]) mem[m_a + 4'(kn - LAT)][7:0]  <= mem_dq_o[7:0];
        if (!mem_be_n[1]) mem[m_a + 4'(kn - LAT)][15:8] <= mem_dq_o[15:8];
      end
      if (!m_we && kn >= LAT - 1 && kn <= LAT + BL - 2)
        mem_dq_i <= mem[m_a + 4'(kn - LAT + 1)];
      mem_wait <= !m_we && (kn >= LAT - 2) && !wait_bad;
    end
  end

  // Scoreboard for read beats.
  logic [15:0] exp_q [$];
  logic [15:0] shadow [16];

  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        chk("R4/R5 unexpected rd_valid", 32'(rd_data), 32'hffffffff);
      end else begin
        chk("R4 read beat", 32'(rd_data), 32'(exp_q.pop_front()));
      end
    end
  end

  logic exp_err = 1'b0;

  task automatic burst(input logic we, input logic [3:0] a, input logic [1:0] be,
                       input logic [15:0] d [4], input bit chk_gap, input bit abort);
    int n_hi, n_lo, n_rdy, n_oe, bi, bad_dir, bad_be, guard;
    req_we = we; req_addr = 22'(a); req_be = be; req = 1'b1;
    n_hi = 0;
    while (mem_adv_n) begin
      if (mem_cs_n) n_hi++;
      @(negedge clk);
    end
    req = 1'b0;
    chk("R2 cs low with adv", 32'(mem_cs_n), 32'h0);
    chk("R2 address", 32'(mem_addr), 32'(a));
    if (chk_gap) chk("R8 gap cycles", 32'(n_hi), 32'(GAP_CYC + 1));
    if (we) begin
      for (int b = 0; b < BL; b++) begin
        if (be[0]) shadow[a + 4'(b)][7:0]  = d[b][7:0];
        if (be[1]) shadow[a + 4'(b)][15:8] = d[b][15:8];
      end
    end else if (!abort) begin
      for (int b = 0; b < BL; b++) exp_q.push_back(shadow[a + 4'(b)]);
    end
    n_lo = 1; n_rdy = 0; n_oe = 0; bi = 0; bad_dir = 0; bad_be = 0; guard = 0;
    if (mem_be_n != ~be) bad_be++;
    @(negedge clk);
    chk("R2 adv one cycle", 32'(mem_adv_n), 32'h1);
    while (!ack && guard < 100) begin
      guard++;
      if (!mem_cs_n) begin
        n_lo++;
        if (mem_be_n != ~be) bad_be++;
        if (we && (mem_we_n || !mem_oe_n)) bad_dir++;
        if (!we && (!mem_we_n || mem_oe_n)) bad_dir++;
      end
      if (mem_dq_oe) begin
        if (n_oe < BL) chk("R3 driven beat", 32'(mem_dq_o), 32'(d[n_oe]));
        n_oe++;
      end
      if (wr_rdy) begin
        wr_data = d[bi % BL];
        bi++;
        n_rdy++;
      end
      @(negedge clk);
    end
    chk("R7 ack seen", 32'(ack), 32'h1);
    chk("R7 ack with cs high", 32'(mem_cs_n), 32'h1);
    chk(abort ? "R5 aborted cs low cycles" : "R7 cs low cycles", 32'(n_lo),
        32'(abort ? LAT - 1 : LAT + BL - 1));
    chk(we ? "R3 strobes" : "R4 strobes", 32'(bad_dir), 32'h0);
    chk("R10 byte enables", 32'(bad_be), 32'h0);
    if (we) begin
      chk("R3 wr_rdy count", 32'(n_rdy), 32'(BL));
      chk("R6 beats driven with WAIT low", 32'(n_oe), 32'(BL));
    end else begin
      chk("R4 bus not driven", 32'(n_oe), 32'h0);
    end
    if (abort) exp_err = 1'b1;
    chk(abort ? "R5 err set" : "R11 err value", 32'(err), 32'(exp_err));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk("watchdog", 32'h1, 32'h0);
    finish_run();
  end

  initial begin
    int n_lo, n_rdy;
    for (int i = 0; i < 16; i++) begin
      mem[i] = 16'h0;
      shadow[i] = 16'h0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 reset strobes", {28'h0, mem_cs_n, mem_adv_n, mem_we_n, mem_oe_n}, 32'hf);
    chk("R1 reset be_n", 32'(mem_be_n), 32'h3);
    chk("R1 reset outputs", {27'h0, mem_dq_oe, ack, err, rd_valid, wr_rdy}, 32'h0);

    burst(1'b1, 4'h0, 2'b11, '{16'h1111, 16'h2222, 16'h3333, 16'h4444}, 1'b0, 1'b0);
    burst(1'b1, 4'h4, 2'b11, '{16'ha0a1, 16'hb2b3, 16'hc4c5, 16'hd6d7}, 1'b1, 1'b0);
    burst(1'b0, 4'h0, 2'b11, '{16'h0, 16'h0, 16'h0, 16'h0}, 1'b1, 1'b0);
    burst(1'b1, 4'h0, 2'b01, '{16'hffab, 16'hffcd, 16'hffef, 16'hff01}, 1'b1, 1'b0);
    burst(1'b0, 4'h0, 2'b11, '{16'h0, 16'h0, 16'h0, 16'h0}, 1'b1, 1'b0);
    burst(1'b1, 4'h2, 2'b10, '{16'h9900, 16'h8800, 16'h7700, 16'h6600}, 1'b1, 1'b0);
    burst(1'b0, 4'h2, 2'b11, '{16'h0, 16'h0, 16'h0, 16'h0}, 1'b1, 1'b0);
    wait_bad = 1'b1;
    burst(1'b0, 4'h0, 2'b11, '{16'h0, 16'h0, 16'h0, 16'h0}, 1'b1, 1'b1);
    wait_bad = 1'b0;
    burst(1'b0, 4'h4, 2'b11, '{16'h0, 16'h0, 16'h0, 16'h0}, 1'b1, 1'b0);
    repeat (4) @(negedge clk);
    chk("R4 all read beats returned", 32'(exp_q.size()), 32'h0);
    chk("R11 err still set", 32'(err), 32'h1);

    // Truncation on the short-limit instance.
    c_req = 1'b1;
    while (c_adv_n) @(negedge clk);
    c_req = 1'b0;
    n_lo = 0; n_rdy = 0;
    for (int g = 0; g < 40 && !c_ack; g++) begin
      if (!c_cs_n) n_lo++;
      if (c_wr_rdy) n_rdy++;
      @(negedge clk);
    end
    chk("R9 cut cs low cycles", 32'(n_lo), 32'(CUT_CYC));
    chk("R9 cut write requests", 32'(n_rdy), 32'(CUT_CYC - LAT + 1));
    chk("R9 cut ack", 32'(c_ack), 32'h1);
    chk("R9 cut err", 32'(c_err), 32'h1);
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule